// File: doc/BRIEF.md
# Raster-Operation Block Transfer Engine

This block moves a rectangle of pixels from one place in a byte-addressed video memory to another. Each destination element is read, combined with the matching source element through a selectable raster operation, and written back. The scan runs forward from the lowest address or backward from the highest, and elements may be one byte or a little-endian byte pair.

Software programs the rectangle (source and destination start addresses, a signed line pitch for each, a width in bytes and a height in lines), the scan direction, the element size, the raster operation, an optional colour key and an address mask. It then pulses `start`. The engine samples every setting on that pulse and walks the rectangle through a single read/write memory port with a one-cycle read latency. `busy` is high while it works, and a one-cycle `done` pulse marks the end. A transparent mode drops every write whose raster-op result equals the colour key. A forward transfer whose line step would be negative is refused outright.

Top module: `rop_blit_engine`

## Requirements
- R1: While reset is held and after it is released with no start pulse, `busy`, `done`, `mem_rd` and `mem_wr` are all low.
- R2: `cfg_rop` selects the value written: 0 all zeros, 1 source AND destination, 2 source, 3 NOT source, 4 source OR destination, 5 source XOR destination, 6 destination unchanged, 7 all ones.
- R3: In a forward transfer, both addresses grow by the element size after each element. At each line end they also add their pitch minus the width.
- R4: In a backward transfer, both addresses shrink by the element size after each element. At each line end they also add their pitch plus the width. The start addresses name the last byte of the rectangle.
- R5: A start with zero height or zero width, or a forward start with height above one where either pitch minus width is negative, performs no memory access. It gives `done` on the next cycle while `busy` stays low.
- R6: With `cfg_transp` set, a write is dropped when the result equals the key. The key is `cfg_key_lo` for byte elements and `{cfg_key_hi, cfg_key_lo}` for pair elements.
- R7: With `cfg_wide` set, elements are byte pairs. The low byte sits at the even address, `mem_addr` bit 0 is cleared, the column count advances by 2 per element and the addresses move by 2. In a backward scan each pair is accessed at the current address minus one.
- R8: Every address driven on `mem_addr` is the computed address ANDed with `cfg_addr_mask`.
- R9: Each element costs a source read, then a destination read, then at most one write. Read data is taken one cycle after `mem_rd`, and the element's write completes before the next element's first read.
- R10: `busy` rises on the clock edge that accepts `start`. After the last element, `busy` falls and `done` is high for exactly one cycle.
- R11: A start pulse while `busy` is ignored, and changing any `cfg_*` input after the accepting edge does not alter the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, sampled when idle |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_src_pitch | input | AW+1 | Signed source line pitch in bytes |
| cfg_dst_pitch | input | AW+1 | Signed destination line pitch in bytes |
| cfg_width | input | AW | Rectangle width in bytes |
| cfg_height | input | HW | Rectangle height in lines |
| cfg_backward | input | 1 | 1 = descending scan |
| cfg_wide | input | 1 | 1 = two-byte elements |
| cfg_transp | input | 1 | 1 = colour-key write suppression |
| cfg_key_lo | input | 8 | Key low byte |
| cfg_key_hi | input | 8 | Key high byte (pair elements) |
| cfg_rop | input | 3 | Raster operation code |
| cfg_addr_mask | input | AW | Address mask |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_wide | output | 1 | Access is a byte pair |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 16 | Write data, byte elements in bits 7:0 |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |

## Verification
A dropped colour-key write and a line-end address step can land on the same element, in the cycle that would have carried the write. The bench provokes this by filling memory with a four-value pattern and choosing keys that often match the results at line ends. Any wrong advance shows up as a shifted image and a wrong write count. The accept edge of `start` can also coincide with the abort decision. Zero-size and negative-step starts are therefore judged by `done` and `busy` on the following cycle and by the absence of any memory access.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [2:0] {
    ROP_ZERO = 3'd0,
    ROP_AND  = 3'd1,
    ROP_SRC  = 3'd2,
    ROP_NSRC = 3'd3,
    ROP_OR   = 3'd4,
    ROP_XOR  = 3'd5,
    ROP_DST  = 3'd6,
    ROP_ONES = 3'd7
  } rop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RSRC = 2'd1,
    ST_RDST = 2'd2,
    ST_WR   = 2'd3
  } blit_st_e;
endpackage

// File: rtl/blit_rop_unit.sv
module blit_rop_unit
  import blit_pkg::*;
#(
  parameter int DW = 16
) (
  input  rop_e            op,
  input  logic [DW-1:0]   src,
  input  logic [DW-1:0]   dst,
  input  logic [DW-1:0]   key,
  input  logic            wide,
  input  logic            transp,
  output logic [DW-1:0]   res,
  output logic            keep
);
  localparam int HB = DW / 2;

  logic [DW-1:0] raw;

  always_comb begin
    case (op)
      ROP_ZERO: raw = '0;
      ROP_AND:  raw = src & dst;
      ROP_SRC:  raw = src;
      ROP_NSRC: raw = ~src;
      ROP_OR:   raw = src | dst;
      ROP_XOR:  raw = src ^ dst;
      ROP_DST:  raw = dst;
      default:  raw = '1;
    endcase
    res  = wide ? raw : {{(DW-HB){1'b0}}, raw[HB-1:0]};
    keep = !(transp && (res == key));
  end
endmodule

// File: rtl/blit_addr_walk.sv
module blit_addr_walk #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic          line_end,
  input  logic          backward,
  input  logic          wide,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] dst_init,
  input  logic [AW+1:0] src_step_in,
  input  logic [AW+1:0] dst_step_in,
  output logic [AW-1:0] src_cur,
  output logic [AW-1:0] dst_cur
);
  localparam int SW = AW + 2;

  logic [AW-1:0] src_q, dst_q, src_nx, dst_nx;
  logic [SW-1:0] sstep_q, dstep_q;
  logic [SW-1:0] mv, sdelta, ddelta;

  always_comb begin
    mv = wide ? SW'(2) : SW'(1);
    if (backward) mv = -mv;
    sdelta = mv + (line_end ? sstep_q : '0);
    ddelta = mv + (line_end ? dstep_q : '0);
    src_nx = src_q;
    dst_nx = dst_q;
    if (load) begin
      src_nx = src_init;
      dst_nx = dst_init;
    end else if (advance) begin
      src_nx = src_q + sdelta[AW-1:0];
      dst_nx = dst_q + ddelta[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      sstep_q <= '0;
      dstep_q <= '0;
    end else begin
      src_q <= src_nx;
      dst_q <= dst_nx;
      if (load) begin
        sstep_q <= src_step_in;
        dstep_q <= dst_step_in;
      end
    end
  end

  assign src_cur = src_q;
  assign dst_cur = dst_q;
endmodule

// File: rtl/rop_blit_engine.sv
module rop_blit_engine
  import blit_pkg::*;
#(
  parameter int AW = 12,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [AW:0]   cfg_src_pitch,
  input  logic [AW:0]   cfg_dst_pitch,
  input  logic [AW-1:0] cfg_width,
  input  logic [HW-1:0] cfg_height,
  input  logic          cfg_backward,
  input  logic          cfg_wide,
  input  logic          cfg_transp,
  input  logic [7:0]    cfg_key_lo,
  input  logic [7:0]    cfg_key_hi,
  input  logic [2:0]    cfg_rop,
  input  logic [AW-1:0] cfg_addr_mask,
  output logic          busy,
  output logic          done,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          mem_wide,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata
);
  localparam int SW = AW + 2;

  blit_st_e      st_q, st_nx;
  logic [AW:0]   x_q, x_nx;
  logic [HW:0]   y_q, y_nx;
  logic          done_q, done_nx;
  logic [15:0]   src_q;
  logic [AW-1:0] width_q, mask_q;
  logic [HW-1:0] height_q;
  logic          back_q, wide_q, transp_q;
  logic [15:0]   key_q;
  rop_e          rop_q;

  logic          accept, refuse;
  logic [SW-1:0] wext, spext, dpext, sfwd, dfwd, sstep, dstep;
  logic          advance, line_end, last_elem;
  logic [AW:0]   x_inc;
  logic [AW-1:0] src_cur, dst_cur, cur, base, align;
  logic [15:0]   res;
  logic          keep;

  // start decode and line-step arithmetic on the live configuration
  always_comb begin
    wext   = {2'b00, cfg_width};
    spext  = {cfg_src_pitch[AW], cfg_src_pitch};
    dpext  = {cfg_dst_pitch[AW], cfg_dst_pitch};
    sfwd   = spext - wext;
    dfwd   = dpext - wext;
    sstep  = cfg_backward ? spext + wext : sfwd;
    dstep  = cfg_backward ? dpext + wext : dfwd;
    accept = start && (st_q == ST_IDLE);
    refuse = (cfg_height == '0) || (cfg_width == '0) ||
             (!cfg_backward && (cfg_height > HW'(1)) && (sfwd[SW-1] || dfwd[SW-1]));
  end

  // element and line counting
  always_comb begin
    x_inc     = x_q + (wide_q ? (AW+1)'(2) : (AW+1)'(1));
    line_end  = x_inc >= {1'b0, width_q};
    last_elem = line_end && ((y_q + (HW+1)'(1)) == {1'b0, height_q});
    advance   = (st_q == ST_WR);
  end

  // next-state logic
  always_comb begin
    st_nx   = st_q;
    x_nx    = x_q;
    y_nx    = y_q;
    done_nx = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          x_nx = '0;
          y_nx = '0;
          if (refuse) done_nx = 1'b1;
          else        st_nx   = ST_RSRC;
        end
      end
      ST_RSRC: st_nx = ST_RDST;
      ST_RDST: st_nx = ST_WR;
      default: begin
        if (last_elem) begin
          st_nx   = ST_IDLE;
          done_nx = 1'b1;
        end else begin
          st_nx = ST_RSRC;
          if (line_end) begin
            x_nx = '0;
            y_nx = y_q + (HW+1)'(1);
          end else begin
            x_nx = x_inc;
          end
        end
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      x_q    <= '0;
      y_q    <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_nx;
      x_q    <= x_nx;
      y_q    <= y_nx;
      done_q <= done_nx;
    end
  end

  // configuration captured on the accepting edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q  <= '0;
      height_q <= '0;
      mask_q   <= '0;
      back_q   <= 1'b0;
      wide_q   <= 1'b0;
      transp_q <= 1'b0;
      key_q    <= '0;
      rop_q    <= ROP_ZERO;
    end else if (accept) begin
      width_q  <= cfg_width;
      height_q <= cfg_height;
      mask_q   <= cfg_addr_mask;
      back_q   <= cfg_backward;
      wide_q   <= cfg_wide;
      transp_q <= cfg_transp;
      key_q    <= cfg_wide ? {cfg_key_hi, cfg_key_lo} : {8'h00, cfg_key_lo};
      rop_q    <= rop_e'(cfg_rop);
    end
  end

  // source operand holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                src_q <= '0;
    else if (st_q == ST_RDST)  src_q <= mem_rdata;
  end

  blit_addr_walk #(.AW(AW)) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .advance     (advance),
    .line_end    (line_end),
    .backward    (back_q),
    .wide        (wide_q),
    .src_init    (cfg_src_addr),
    .dst_init    (cfg_dst_addr),
    .src_step_in (sstep),
    .dst_step_in (dstep),
    .src_cur     (src_cur),
    .dst_cur     (dst_cur)
  );

  blit_rop_unit #(.DW(16)) u_rop (
    .op     (rop_q),
    .src    (src_q),
    .dst    (mem_rdata),
    .key    (key_q),
    .wide   (wide_q),
    .transp (transp_q),
    .res    (res),
    .keep   (keep)
  );

  // memory port
  always_comb begin
    cur   = (st_q == ST_RSRC) ? src_cur : dst_cur;
    base  = (wide_q && back_q) ? cur - AW'(1) : cur;
    align = wide_q ? {{(AW-1){1'b1}}, 1'b0} : '1;
    mem_addr  = base & mask_q & align;
    mem_rd    = (st_q == ST_RSRC) || (st_q == ST_RDST);
    mem_wr    = (st_q == ST_WR) && keep;
    mem_wide  = wide_q;
    mem_wdata = res;
  end

  assign busy = (st_q != ST_IDLE);
  assign done = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr)); // R9
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd)); // R9
  AST_PAIR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && mem_wide) |-> !mem_addr[0]); // R7
  AST_ADDR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> ((mem_addr & ~mask_q) == '0)); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
endmodule

// File: tb/sim_rop_blit_engine.sv
module sim_rop_blit_engine;
  localparam int AW = 12;
  localparam int HW = 8;
  localparam int MSZ = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [AW-1:0] cfg_src_addr, cfg_dst_addr, cfg_width, cfg_addr_mask;
  logic [AW:0]   cfg_src_pitch, cfg_dst_pitch;
  logic [HW-1:0] cfg_height;
  logic cfg_backward, cfg_wide, cfg_transp;
  logic [7:0] cfg_key_lo, cfg_key_hi;
  logic [2:0] cfg_rop;
  logic busy, done, mem_rd, mem_wr, mem_wide;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  logic [7:0] mem [0:MSZ-1];
  logic [7:0] refm [0:MSZ-1];
  int rd_cnt = 0, wr_cnt = 0;
  int checks = 0, fails = 0;
  int exp_elems, exp_writes;

  always #2 clk = ~clk;

  rop_blit_engine #(.AW(AW), .HW(HW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .cfg_src_pitch(cfg_src_pitch), .cfg_dst_pitch(cfg_dst_pitch),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_backward(cfg_backward), .cfg_wide(cfg_wide), .cfg_transp(cfg_transp),
    .cfg_key_lo(cfg_key_lo), .cfg_key_hi(cfg_key_hi), .cfg_rop(cfg_rop),
    .cfg_addr_mask(cfg_addr_mask),
    .busy(busy), .done(done), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // memory with one-cycle read latency, little-endian pairs
  always @(posedge clk) begin
    if (mem_rd) begin
      rd_cnt <= rd_cnt + 1;
      mem_rdata <= mem_wide ? {mem[int'(mem_addr) + 1], mem[mem_addr]} : {8'h00, mem[mem_addr]};
    end
    if (mem_wr) begin
      wr_cnt <= wr_cnt + 1;
      mem[mem_addr] <= mem_wdata[7:0];
      if (mem_wide) mem[int'(mem_addr) + 1] <= mem_wdata[15:8];
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rop_f(int op, int s, int d, int m);
    int r;
    case (op)
      0: r = 0;
      1: r = s & d;
      2: r = s;
      3: r = ~s;
      4: r = s | d;
      5: r = s ^ d;
      6: r = d;
      default: r = 'hFFFF;
    endcase
    return r & m;
  endfunction

  task automatic fill(int seed);
    for (int i = 0; i < MSZ; i++) begin
      mem[i]  = 8'(((i * 5) + (i >> 4) + seed) % 4);
      refm[i] = mem[i];
    end
  endtask

  // reference walk computed from R2..R8
  task automatic model();
    int s, d, w, h, es, ss, ds, msk, dm, key, sa, da, sv, dv, r;
    bit bk, wd, tr;
    s = int'(cfg_src_addr); d = int'(cfg_dst_addr);
    w = int'(cfg_width); h = int'(cfg_height);
    bk = cfg_backward; wd = cfg_wide; tr = cfg_transp;
    msk = int'(cfg_addr_mask);
    es = wd ? 2 : 1;
    dm = wd ? 'hFFFF : 'hFF;
    key = wd ? {cfg_key_hi, cfg_key_lo} : int'(cfg_key_lo);
    exp_elems = 0; exp_writes = 0;
    if (h == 0 || w == 0) return;
    if (!bk) begin
      ss = $signed(cfg_src_pitch) - w;
      ds = $signed(cfg_dst_pitch) - w;
      if (h > 1 && (ss < 0 || ds < 0)) return;
    end else begin
      ss = $signed(cfg_src_pitch) + w;
      ds = $signed(cfg_dst_pitch) + w;
    end
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x += es) begin
        sa = ((bk && wd) ? s - 1 : s) & (MSZ - 1) & msk & (wd ? ~1 : ~0);
        da = ((bk && wd) ? d - 1 : d) & (MSZ - 1) & msk & (wd ? ~1 : ~0);
        sv = wd ? {refm[sa + 1], refm[sa]} : int'(refm[sa]);
        dv = wd ? {refm[da + 1], refm[da]} : int'(refm[da]);
        r = rop_f(int'(cfg_rop), sv, dv, dm);
        exp_elems++;
        if (!(tr && r == key)) begin
          exp_writes++;
          refm[da] = 8'(r);
          if (wd) refm[da + 1] = 8'(r >> 8);
        end
        s += bk ? -es : es;
        d += bk ? -es : es;
      end
      s += ss;
      d += ds;
    end
  endtask

  task automatic run(string lbl, bit disturb);
    int rd0, wr0, n, bad, first;
    bit seen;
    model();
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (exp_elems == 0) begin
      check(done && !busy, {lbl, " R5 done next cycle, busy low"}, {30'd0, done, busy}, 2);
    end else begin
      check(busy && !done, {lbl, " R10 busy after start"}, {30'd0, busy, done}, 2);
    end
    seen = done;
    n = 0;
    while (!seen && n < 4000) begin
      if (disturb && n == 4) begin
        cfg_dst_addr = 12'h500; cfg_rop = 3'd5; cfg_width = 12'd2;
        start = 1'b1;
      end
      if (disturb && n == 5) start = 1'b0;
      @(negedge clk);
      n++;
      seen = done;
    end
    check(seen && !busy, {lbl, " R10 done with busy low"}, {30'd0, seen, busy}, 2);
    @(negedge clk);
    check(!done && !busy, {lbl, " R10 done lasts one cycle"}, int'(done), 0);
    check(wr_cnt - wr0 == exp_writes, {lbl, " R6 R9 write count"}, wr_cnt - wr0, exp_writes);
    check(rd_cnt - rd0 == 2 * exp_elems, {lbl, " R9 read count"}, rd_cnt - rd0, 2 * exp_elems);
    bad = 0; first = -1;
    for (int i = 0; i < MSZ; i++) begin
      if (mem[i] !== refm[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) first = 0;
    check(bad == 0, {lbl, " memory image"}, int'(mem[first]), int'(refm[first]));
  endtask

  task automatic setup(int sa, int da, int sp, int dp, int w, int h, bit bk, bit wd, bit tr, int op);
    cfg_src_addr = 12'(sa); cfg_dst_addr = 12'(da);
    cfg_src_pitch = 13'(sp); cfg_dst_pitch = 13'(dp);
    cfg_width = 12'(w); cfg_height = 8'(h);
    cfg_backward = bk; cfg_wide = wd; cfg_transp = tr; cfg_rop = 3'(op);
    cfg_key_lo = 8'd1; cfg_key_hi = 8'd2; cfg_addr_mask = 12'hFFF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    string lbl;
    rst_n = 1'b0;
    start = 1'b0;
    setup(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    fill(0);
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_rd && !mem_wr, "R1 outputs in reset",
          {28'd0, busy, done, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !mem_rd && !mem_wr, "R1 outputs after reset",
          {28'd0, busy, done, mem_rd, mem_wr}, 0);

    // sweep every raster op over both directions, both sizes, key on/off
    for (int op = 0; op < 8; op++)
      for (int bk = 0; bk < 2; bk++)
        for (int wd = 0; wd < 2; wd++)
          for (int tr = 0; tr < 2; tr++) begin
            fill(op + bk + wd + tr);
            if (bk == 0) setup('h100, 'h140, 16, 20, 6, 4, 1'(bk), 1'(wd), 1'(tr), op);
            else         setup('h1A5, 'h2B3, -16, -20, 6, 4, 1'(bk), 1'(wd), 1'(tr), op);
            lbl = $sformatf("R2 op%0d %s%s%s", op, bk ? "R4" : "R3",
                            wd ? " R7" : "", tr ? " R6" : "");
            run(lbl, 1'b0);
          end

    fill(3); setup('h221, 'h331, -12, -12, 5, 3, 1, 1, 1, 5);
    run("R7 R4 odd width pairs", 1'b0);
    fill(1); setup('h100, 'h103, 16, 16, 8, 3, 0, 0, 0, 2);
    run("R3 overlapping forward copy", 1'b0);
    fill(2); setup('h040, 'h3C1, 16, 16, 6, 3, 0, 1, 0, 5);
    cfg_addr_mask = 12'h1FF;
    run("R8 masked addresses", 1'b0);
    fill(0); setup('h100, 'h140, 3, 16, 5, 2, 0, 0, 0, 2);
    run("R5 negative source step", 1'b0);
    fill(0); setup('h100, 'h140, 16, 2, 5, 3, 0, 1, 0, 2);
    run("R5 negative destination step", 1'b0);
    fill(0); setup('h100, 'h140, 3, 2, 5, 1, 0, 0, 0, 2);
    run("R5 single line negative step allowed", 1'b0);
    fill(0); setup('h100, 'h140, 16, 16, 5, 0, 0, 0, 0, 2);
    run("R5 zero height", 1'b0);
    fill(0); setup('h100, 'h140, 16, 16, 0, 3, 0, 0, 0, 2);
    run("R5 zero width", 1'b0);
    fill(2); setup('h100, 'h180, 16, 16, 6, 4, 0, 0, 0, 2);
    run("R11 restart and config change ignored", 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule